// File: doc/BRIEF.md
# In-Memory Row Copy Command Sequencer

This block sits on the controller side of a DRAM and converts one bulk row-copy request into the string of commands that makes the memory copy a whole row internally. No row data crosses the external data bus. A request names a source and a destination. Each of them is given as a bank, a subarray and a row. The sequencer compares the two and picks one of three routes.

When both rows share a subarray, two activations in a row copy the data through the shared row buffer: the first latches the source and the second overwrites the destination. When the rows sit in different banks, both rows are opened and the row is streamed across the narrow internal bus, one beat per cycle. When the rows are in different subarrays of one bank, the bank-to-bank route is used twice, with a scratch row in a neighbouring bank as the stopover. Every route ends by closing its banks. A minimum settle time follows every activation, and a precharge recovery time passes before the block reports completion.

A request whose source and destination are the same row is finished at once, with no command.

Top module: `rowcopy_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `cmd_valid` are 0 and `req_ready` is 1.
- R2: Same bank and same subarray, different row: the block issues ACT to the source row, then ACT to the destination row, then one PRE to that bank, with no PRE between the two ACTs.
- R3: Different banks: the block issues ACT to the source row, then ACT to the destination row, and then the transfer beats.
- R4: A bank-to-bank transfer is exactly ROW_BYTES/BUS_BYTES consecutive XFER cycles. During each of them `cmd_bank` is the sending bank and `cmd_bank2` is the receiving bank.
- R5: Same bank, different subarray: a first pass copies from the source to a scratch row, then a second pass copies from the scratch row to the destination. The scratch row is in the bank whose number is the source bank with bit 0 inverted, at subarray 0, row SCRATCH_ROW.
- R6: After an ACT, the next ACT, PRE or XFER command comes exactly T_RAS cycles later.
- R7: A pass that uses two banks ends with PRE to the sending bank, then PRE to the receiving bank in the next cycle. The next ACT, or the completion, comes exactly T_RP cycles after the last PRE.
- R8: `req_ready` is 1 only while the block is idle. A `req_valid` that is raised while the block is busy is not taken.
- R9: `done` is high for exactly one cycle per accepted request. In that cycle `busy` is 0.
- R10: A request whose source and destination are the same row raises `done` in the cycle after acceptance and issues no command.
- R11: The encoding of `cmd_op` is 0 for no command, 1 for ACT, 2 for PRE and 3 for XFER. `cmd_valid` is never high together with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Copy request offered |
| req_ready | output | 1 | Request is taken on this edge when valid |
| req_src_bank | input | BANK_W | Source bank |
| req_src_sub | input | SUB_W | Source subarray |
| req_src_row | input | ROW_W | Source row inside its subarray |
| req_dst_bank | input | BANK_W | Destination bank |
| req_dst_sub | input | SUB_W | Destination subarray |
| req_dst_row | input | ROW_W | Destination row inside its subarray |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | Command code (see R11) |
| cmd_bank | output | BANK_W | Target bank, or sending bank for XFER |
| cmd_sub | output | SUB_W | Subarray for ACT |
| cmd_row | output | ROW_W | Row for ACT |
| cmd_bank2 | output | BANK_W | Receiving bank for XFER, zero otherwise |

## Verification
Copies are requested in four shapes:
- a same-subarray pair, which separates the two-activation route from the transfer routes;
- a cross-bank pair, which shows that the beat count and the bank pairing on the transfer are right;
- a same-bank, cross-subarray pair, which shows that the scratch-bank choice and the order of the two passes are right;
- a same-row pair, which must produce only a completion pulse.

Every command and completion is compared against an expected list, including the cycle in which it appears. A wrong wait, a missing precharge or a reordered pass therefore shows up as a mismatch. A request raised during a long transfer checks that a busy block takes no new work.

// File: rtl/rowcopy_pkg.sv
// Shared encodings for the row copy sequencer.
// Assumes: command codes are fixed by the external command interface.
package rowcopy_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_PRE  = 2'd2,
        CMD_XFER = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_LOCAL  = 2'd1,
        MODE_XBANK  = 2'd2,
        MODE_TWOHOP = 2'd3
    } copy_mode_e;

endpackage

// File: rtl/rowcopy_mode_dec.sv
// Classifies a copy request by where its two rows sit.
// Assumes: addresses are stable while being decoded; purely combinational.
module rowcopy_mode_dec
    import rowcopy_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int SUB_W  = 2,
    parameter int ROW_W  = 8
) (
    input  logic [BANK_W-1:0] src_bank,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [ROW_W-1:0]  src_row,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [SUB_W-1:0]  dst_sub,
    input  logic [ROW_W-1:0]  dst_row,
    output copy_mode_e        mode
);

    // Choose the copy route from bank and subarray equality
    always_comb begin
        if (src_bank != dst_bank)
            mode = MODE_XBANK;
        else if (src_sub != dst_sub)
            mode = MODE_TWOHOP;
        else if (src_row != dst_row)
            mode = MODE_LOCAL;
        else
            mode = MODE_NONE;
    end

endmodule

// File: rtl/rowcopy_timer.sv
// Loadable down-counter used for the activation and precharge waits.
// Assumes: load values are at least 1; expired means the wait is over.
module rowcopy_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down towards one
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt > W'(1))
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt <= W'(1));

endmodule

// File: rtl/rowcopy_beat_ctr.sv
// Counts internal-bus beats of one row transfer.
// Assumes: clear and enable are never high together; BEATS >= 1.
module rowcopy_beat_ctr #(
    parameter int BEATS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic last
);

    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] TERMINAL = BW'(BEATS - 1);

    logic [BW-1:0] beat;

    // Advance one beat per enabled cycle, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            beat <= '0;
        else if (en && !last)
            beat <= beat + BW'(1);
    end

    assign last = (beat == TERMINAL);

endmodule

// File: rtl/rowcopy_seq.sv
// Row copy command sequencer: accepts one copy request while idle, then
// issues ACT/PRE/XFER commands for the chosen route and pulses done.
// Assumes: T_RAS >= 2, T_RP >= 2, BUS_BYTES divides ROW_BYTES, BANK_W >= 1.
module rowcopy_seq
    import rowcopy_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int SUB_W       = 2,
    parameter int ROW_W       = 8,
    parameter int ROW_BYTES   = 4096,
    parameter int BUS_BYTES   = 1,
    parameter int T_RAS       = 4,
    parameter int T_RP        = 3,
    parameter int SCRATCH_ROW = (1 << ROW_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_src_bank,
    input  logic [SUB_W-1:0]  req_src_sub,
    input  logic [ROW_W-1:0]  req_src_row,
    input  logic [BANK_W-1:0] req_dst_bank,
    input  logic [SUB_W-1:0]  req_dst_sub,
    input  logic [ROW_W-1:0]  req_dst_row,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [BANK_W-1:0] cmd_bank2
);

    localparam int BEATS = ROW_BYTES / BUS_BYTES;
    localparam int TMAX  = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RAS_LOAD = TW'(T_RAS - 1);
    localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP - 1);
    localparam logic [ROW_W-1:0] SCR_ROW = ROW_W'(SCRATCH_ROW);

    typedef enum logic [3:0] {
        ST_IDLE, ST_ACT_A, ST_WAIT_A, ST_ACT_B, ST_WAIT_B,
        ST_XFER, ST_PRE_A, ST_PRE_B, ST_WAIT_P
    } state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SUB_W-1:0]  sub;
        logic [ROW_W-1:0]  row;
    } loc_t;

    state_e     state_q, state_d;
    copy_mode_e req_mode, mode_q;
    loc_t       a_q, b_q, dst_q;
    logic       hop2_q;
    logic       done_q;
    logic       tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic       beat_clear, beat_en, beat_last;
    logic       accept;

    rowcopy_mode_dec #(
        .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W)
    ) i_dec (
        .src_bank (req_src_bank),
        .src_sub  (req_src_sub),
        .src_row  (req_src_row),
        .dst_bank (req_dst_bank),
        .dst_sub  (req_dst_sub),
        .dst_row  (req_dst_row),
        .mode     (req_mode)
    );

    rowcopy_timer #(.W(TW)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    rowcopy_beat_ctr #(.BEATS(BEATS)) i_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (beat_clear),
        .en    (beat_en),
        .last  (beat_last)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;

    // Timer loads on every ACT (settle) and on the closing PRE (recovery)
    always_comb begin
        tmr_load = (state_q == ST_ACT_A) || (state_q == ST_ACT_B) || (state_q == ST_PRE_B);
        tmr_val  = (state_q == ST_PRE_B) ? RP_LOAD : RAS_LOAD;
    end

    assign beat_clear = (state_q == ST_ACT_B);
    assign beat_en    = (state_q == ST_XFER);

    // Next-state selection for the command sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && req_mode != MODE_NONE) state_d = ST_ACT_A;
            ST_ACT_A:  state_d = ST_WAIT_A;
            ST_WAIT_A: if (tmr_exp) state_d = ST_ACT_B;
            ST_ACT_B:  state_d = ST_WAIT_B;
            ST_WAIT_B: if (tmr_exp) state_d = (mode_q == MODE_LOCAL) ? ST_PRE_B : ST_XFER;
            ST_XFER:   if (beat_last) state_d = ST_PRE_A;
            ST_PRE_A:  state_d = ST_PRE_B;
            ST_PRE_B:  state_d = ST_WAIT_P;
            ST_WAIT_P: if (tmr_exp)
                           state_d = (mode_q == MODE_TWOHOP && !hop2_q) ? ST_ACT_A : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, route endpoints and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_NONE;
            a_q     <= '0;
            b_q     <= '0;
            dst_q   <= '0;
            hop2_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (state_q == ST_IDLE && accept) begin
                mode_q <= req_mode;
                hop2_q <= 1'b0;
                a_q    <= '{req_src_bank, req_src_sub, req_src_row};
                dst_q  <= '{req_dst_bank, req_dst_sub, req_dst_row};
                if (req_mode == MODE_TWOHOP)
                    b_q <= '{req_src_bank ^ BANK_W'(1), SUB_W'(0), SCR_ROW};
                else
                    b_q <= '{req_dst_bank, req_dst_sub, req_dst_row};
                if (req_mode == MODE_NONE)
                    done_q <= 1'b1;
            end
            if (state_q == ST_WAIT_P && tmr_exp) begin
                if (mode_q == MODE_TWOHOP && !hop2_q) begin
                    a_q    <= b_q;
                    b_q    <= dst_q;
                    hop2_q <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Command outputs decoded from the current state
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = CMD_NOP;
        cmd_bank  = '0;
        cmd_sub   = '0;
        cmd_row   = '0;
        cmd_bank2 = '0;
        unique case (state_q)
            ST_ACT_A: begin
                cmd_valid = 1'b1; cmd_op = CMD_ACT;
                cmd_bank = a_q.bank; cmd_sub = a_q.sub; cmd_row = a_q.row;
            end
            ST_ACT_B: begin
                cmd_valid = 1'b1; cmd_op = CMD_ACT;
                cmd_bank = b_q.bank; cmd_sub = b_q.sub; cmd_row = b_q.row;
            end
            ST_XFER: begin
                cmd_valid = 1'b1; cmd_op = CMD_XFER;
                cmd_bank = a_q.bank; cmd_bank2 = b_q.bank;
            end
            ST_PRE_A: begin
                cmd_valid = 1'b1; cmd_op = CMD_PRE; cmd_bank = a_q.bank;
            end
            ST_PRE_B: begin
                cmd_valid = 1'b1; cmd_op = CMD_PRE; cmd_bank = b_q.bank;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rowcopy_seq_chk.sv
// Protocol checker for rowcopy_seq, attached by bind below.
// Assumes: observes only the ports of the sequencer.
module rowcopy_seq_chk #(
    parameter int BANK_W = 2,
    parameter int T_RAS  = 4,
    parameter int T_RP   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [BANK_W-1:0] cmd_bank2
);

    localparam int CW = $clog2(((T_RAS > T_RP) ? T_RAS : T_RP) + 2);

    logic [CW-1:0] since_act, since_pre;
    logic is_act, is_pre, is_xfer;

    assign is_act  = cmd_valid && (cmd_op == 2'd1);
    assign is_pre  = cmd_valid && (cmd_op == 2'd2);
    assign is_xfer = cmd_valid && (cmd_op == 2'd3);

    // Saturating distance in cycles from the latest ACT and PRE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= CW'(T_RAS);
            since_pre <= CW'(T_RP);
        end else begin
            if (is_act) since_act <= CW'(1);
            else if (since_act < CW'(T_RAS)) since_act <= since_act + CW'(1);
            if (is_pre) since_pre <= CW'(1);
            else if (since_pre < CW'(T_RP)) since_pre <= since_pre + CW'(1);
        end
    end

    // R6
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_pre || is_xfer) |-> since_act >= CW'(T_RAS));

    // R7
    pre_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || is_act) |-> since_pre >= CW'(T_RP));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R8
    accept_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy || done));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(req_valid && req_ready)) |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    // R4
    xfer_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_xfer |-> (cmd_bank != cmd_bank2));

endmodule

bind rowcopy_seq rowcopy_seq_chk #(
    .BANK_W (BANK_W),
    .T_RAS  (T_RAS),
    .T_RP   (T_RP)
) i_rowcopy_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_bank2 (cmd_bank2)
);

// File: tb/test_rowcopy_seq.sv
// Scoreboard bench: the driver queues the expected commands with their cycles,
// and the monitor compares everything the sequencer emits against that queue.
module test_rowcopy_seq;

    localparam int BANK_W = 2, SUB_W = 2, ROW_W = 8;
    localparam int N = 4096, T = 4, P = 3, SCR = 255;
    localparam int OP_ACT = 1, OP_PRE = 2, OP_XFER = 3, OP_DONE = 4;

    typedef struct {
        int    op;
        int    bank;
        int    sub;
        int    row;
        int    bank2;
        int    cyc;
        int    cnt;
        string tag;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready, busy, done, cmd_valid;
    logic [BANK_W-1:0] src_bank = '0, dst_bank = '0, cmd_bank, cmd_bank2;
    logic [SUB_W-1:0]  src_sub = '0, dst_sub = '0, cmd_sub;
    logic [ROW_W-1:0]  src_row = '0, dst_row = '0, cmd_row;
    logic [1:0]        cmd_op;

    int checks = 0, fails = 0, cyc = 0;
    bit started = 1'b0;
    item_t exp_q[$];
    bit in_run = 1'b0;
    item_t run;
    int nop_cmds = 0;

    rowcopy_seq i_rowcopy_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_bank(src_bank), .req_src_sub(src_sub), .req_src_row(src_row),
        .req_dst_bank(dst_bank), .req_dst_sub(dst_sub), .req_dst_row(dst_row),
        .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_sub(cmd_sub), .cmd_row(cmd_row), .cmd_bank2(cmd_bank2)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic item_t mk(input int op, bank, sub, row, bank2, c, cnt, input string tag);
        item_t it;
        it.op = op; it.bank = bank; it.sub = sub; it.row = row;
        it.bank2 = bank2; it.cyc = c; it.cnt = cnt; it.tag = tag;
        return it;
    endfunction

    // Compare one observed item against the head of the expected queue
    task automatic compare(input item_t got);
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected output op", got.op, 0);
            return;
        end
        e = exp_q.pop_front();
        check(got.op == e.op, e.tag, "op", got.op, e.op);
        check(got.cyc == e.cyc, e.tag, "cycle", got.cyc, e.cyc);
        if (e.op != OP_DONE)
            check(got.bank == e.bank, e.tag, "bank", got.bank, e.bank);
        if (e.op == OP_ACT) begin
            check(got.sub == e.sub, e.tag, "subarray", got.sub, e.sub);
            check(got.row == e.row, e.tag, "row", got.row, e.row);
        end
        if (e.op == OP_XFER) begin
            check(got.bank2 == e.bank2, e.tag, "receiving bank", got.bank2, e.bank2);
            check(got.cnt == e.cnt, e.tag, "beat count", got.cnt, e.cnt);
        end
    endtask

    // Monitor: collapse XFER runs, then compare commands and completions
    always @(negedge clk) begin
        if (started) begin
            if (cmd_valid && cmd_op == 2'd0) nop_cmds++;
            if (cmd_valid && cmd_op == 2'd3) begin
                if (!in_run) begin
                    in_run = 1'b1;
                    run = mk(OP_XFER, int'(cmd_bank), 0, 0, int'(cmd_bank2), cyc, 1, "");
                end else begin
                    run.cnt++;
                end
            end else begin
                if (in_run) begin
                    in_run = 1'b0;
                    compare(run);
                end
                if (cmd_valid)
                    compare(mk(int'(cmd_op), int'(cmd_bank), int'(cmd_sub), int'(cmd_row), 0, cyc, 1, ""));
                if (done)
                    compare(mk(OP_DONE, 0, 0, 0, 0, cyc, 1, ""));
            end
        end
    end

    // Push one bank-to-bank pass; returns the cycle after its recovery wait
    function automatic int push_leg(input int s, ab, as_, ar, bb, bs, br, input string tag_act);
        exp_q.push_back(mk(OP_ACT, ab, as_, ar, 0, s, 1, tag_act));
        exp_q.push_back(mk(OP_ACT, bb, bs, br, 0, s + T, 1, (tag_act == "R3") ? "R6" : tag_act));
        exp_q.push_back(mk(OP_XFER, ab, 0, 0, bb, s + 2*T, N, "R4"));
        exp_q.push_back(mk(OP_PRE, ab, 0, 0, 0, s + 2*T + N, 1, "R7"));
        exp_q.push_back(mk(OP_PRE, bb, 0, 0, 0, s + 2*T + N + 1, 1, "R7"));
        return s + 2*T + N + 1 + P;
    endfunction

    // Driver: offer a request, queue the expected outcome once it is taken
    task automatic do_copy(input int sb, ss, sr, db, ds, dr);
        int acc, s, e;
        @(negedge clk);
        src_bank = BANK_W'(sb); src_sub = SUB_W'(ss); src_row = ROW_W'(sr);
        dst_bank = BANK_W'(db); dst_sub = SUB_W'(ds); dst_row = ROW_W'(dr);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        s = acc + 1;
        if (sb == db && ss == ds && sr == dr) begin
            exp_q.push_back(mk(OP_DONE, 0, 0, 0, 0, s, 1, "R10"));
        end else if (sb == db && ss == ds) begin
            exp_q.push_back(mk(OP_ACT, sb, ss, sr, 0, s, 1, "R2"));
            exp_q.push_back(mk(OP_ACT, db, ds, dr, 0, s + T, 1, "R6"));
            exp_q.push_back(mk(OP_PRE, db, 0, 0, 0, s + 2*T, 1, "R2"));
            exp_q.push_back(mk(OP_DONE, 0, 0, 0, 0, s + 2*T + P, 1, "R9"));
        end else if (sb != db) begin
            e = push_leg(s, sb, ss, sr, db, ds, dr, "R3");
            exp_q.push_back(mk(OP_DONE, 0, 0, 0, 0, e, 1, "R7"));
        end else begin
            e = push_leg(s, sb, ss, sr, sb ^ 1, 0, SCR, "R5");
            e = push_leg(e, sb ^ 1, 0, SCR, db, ds, dr, "R5");
            exp_q.push_back(mk(OP_DONE, 0, 0, 0, 0, e, 1, "R5"));
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!(sb == db && ss == ds && sr == dr))
            check(busy && !req_ready, "R8", "busy and not ready after accept",
                  int'({busy, req_ready}), 2);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || busy || in_run) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run still reaches the summary as a failure
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !cmd_valid && req_ready, "R1", "reset outputs",
              int'({busy, done, cmd_valid, req_ready}), 1);
        @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);
        check(!busy && req_ready, "R1", "idle after reset", int'({busy, req_ready}), 1);

        // R2: same subarray, two activations
        do_copy(1, 2, 5, 1, 2, 9);
        wait_idle();

        // R3/R4: cross-bank, with an R8 request raised mid-transfer
        do_copy(0, 1, 3, 2, 3, 7);
        repeat (40) @(negedge clk);
        src_bank = 2'd3; dst_bank = 2'd1; req_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(!req_ready, "R8", "ready while busy", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        wait_idle();

        // R5: same bank, different subarrays through the scratch bank
        do_copy(2, 1, 4, 2, 3, 6);
        wait_idle();

        // R10: identical source and destination
        do_copy(3, 0, 17, 3, 0, 17);
        wait_idle();

        // R2 again, back to back, different bank and rows
        do_copy(0, 0, 0, 0, 0, 255);
        wait_idle();

        check(exp_q.size() == 0, "R9", "outstanding expected items", exp_q.size(), 0);
        // R11: no command carried the no-command code
        check(nop_cmds == 0, "R11", "commands with code 0", nop_cmds, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule